// File: doc/BRIEF.md
# Branch and Loop Decision Unit

This block resolves the branch family of a 16-bit instruction set whose opcode fields are laid out on octal-digit boundaries. The pipeline hands it one instruction word per valid cycle, along with the current negative, zero and carry flags and the instruction pointer. That pointer has already been advanced past the branch word. One cycle later the block reports three things: whether the word was a branch, whether control transfers, and which pointer to fetch next.

The family has seven flag-conditioned forms plus one counted-loop form. The counted loop names a register. The block reads that register through a combinational select and returns the value minus one for write-back. It keeps branching backwards until the decremented value reaches zero, and it ignores the condition flags while doing so. Any word outside the family is reported as not-a-branch and leaves the pointer unchanged.

Top module: `branch_decide`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `taken`, `not_branch` and `wb_en` are all low.
- R2: A word belongs to the branch family when bit 15 is 1 and bits 14:12 are 000. Any other valid word gives `not_branch`=1, `taken`=0, `wb_en`=0 and `next_ip` equal to the `ip_in` it was issued with.
- R3: For branch words, the selector in bits 11:9 picks the condition. Value 1 always branches. Value 2 branches when `flag_z`=1 and value 3 when `flag_z`=0. Value 4 branches when `flag_n`=0, so a zero result counts as positive. Value 5 branches when `flag_n`=1. Value 6 branches when `flag_c`=1 and value 7 when `flag_c`=0.
- R4: A taken conditional branch sets `next_ip` to `ip_in` plus twice the two's-complement value of bits 8:0, modulo 2^16.
- R5: For selector 0 (counted loop), `rd_sel` equals bits 8:6 in the same cycle as the word. One cycle later, `wb_en`=1, `wb_sel` equals bits 8:6 and `wb_data` equals `rd_data` minus one modulo 2^16, so 0 becomes FFFF.
- R6: The counted loop is taken exactly when its decremented value is nonzero. Its target is `ip_in` plus twice the two's-complement value of bits 5:0.
- R7: A branch-family word that is not taken gives `next_ip` = `ip_in` and `taken`=0.
- R8: The results for a word appear in the cycle after it is presented with `in_valid`=1, with `out_valid`=1 for that one cycle. A cycle with `in_valid`=0 gives `out_valid`, `taken`, `not_branch` and `wb_en` all low in the following cycle.
- R9: The counted loop's decision, target and write-back do not depend on the three flag inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| ip_in | input | 16 | Instruction pointer already advanced past the word |
| rd_sel | output | 3 | Register number for the counted-loop read |
| rd_data | input | 16 | Value of the selected register |
| out_valid | output | 1 | Result strobe |
| not_branch | output | 1 | Word was outside the branch family |
| taken | output | 1 | Control transfers to `next_ip` |
| next_ip | output | 16 | Pointer to fetch next |
| wb_en | output | 1 | Write `wb_data` to register `wb_sel` |
| wb_sel | output | 3 | Write-back register number |
| wb_data | output | 16 | Decremented register value |

## Verification
Only the counted loop both redirects the pointer and writes a register, and both happen in the same result cycle. The bench provokes this case by sweeping every register number and a range of loop offsets against read values of 0, 1, 2, 0x8000 and 0xFFFF, under all eight flag combinations. In each result cycle it judges the write-back value, the register number, the taken strobe and the next pointer together. A count of one must give write-back zero with fall-through, and a count of zero must wrap to FFFF and branch.

// File: rtl/branch_decide.sv
module branch_decide #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   instr,
  input  logic          flag_n,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic [AW-1:0] ip_in,
  output logic [2:0]    rd_sel,
  input  logic [DW-1:0] rd_data,
  output logic          out_valid,
  output logic          not_branch,
  output logic          taken,
  output logic [AW-1:0] next_ip,
  output logic          wb_en,
  output logic [2:0]    wb_sel,
  output logic [DW-1:0] wb_data
);
  localparam int OFFW  = 9;
  localparam int LOFFW = 6;

  logic [2:0] sel;
  logic       is_br, is_loop, cond, take;
  logic [DW-1:0] dec;
  logic [AW-1:0] boff, loff, tgt;

  assign sel     = instr[11:9];
  assign is_br   = instr[15] && (instr[14:12] == 3'b000);
  assign is_loop = is_br && (sel == 3'd0);
  assign rd_sel  = instr[8:6];
  assign dec     = rd_data - {{(DW-1){1'b0}}, 1'b1};

  assign boff = {{(AW-OFFW-1){instr[OFFW-1]}}, instr[OFFW-1:0], 1'b0};
  assign loff = {{(AW-LOFFW-1){instr[LOFFW-1]}}, instr[LOFFW-1:0], 1'b0};
  assign tgt  = ip_in + (is_loop ? loff : boff);

  always_comb begin
    case (sel)
      3'd1:    cond = 1'b1;
      3'd2:    cond = flag_z;
      3'd3:    cond = !flag_z;
      3'd4:    cond = !flag_n;
      3'd5:    cond = flag_n;
      3'd6:    cond = flag_c;
      3'd7:    cond = !flag_c;
      default: cond = 1'b0;
    endcase
  end

  assign take = is_br && (is_loop ? (dec != '0) : cond);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      not_branch <= 1'b0;
      taken      <= 1'b0;
      next_ip    <= '0;
      wb_en      <= 1'b0;
      wb_sel     <= '0;
      wb_data    <= '0;
    end else begin
      out_valid  <= in_valid;
      not_branch <= in_valid && !is_br;
      taken      <= in_valid && take;
      wb_en      <= in_valid && is_loop;
      if (in_valid) begin
        next_ip <= take ? tgt : ip_in;
        wb_sel  <= instr[8:6];
        wb_data <= dec;
      end
    end
  end
endmodule

module branch_decide_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [AW-1:0] ip_in,
  input logic [DW-1:0] rd_data,
  input logic          out_valid,
  input logic          not_branch,
  input logic          taken,
  input logic [AW-1:0] next_ip,
  input logic          wb_en,
  input logic [DW-1:0] wb_data
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !taken && !wb_en && !not_branch); // R8
  AST_RESULT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R8
  AST_NONBRANCH_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    not_branch |-> !taken && !wb_en && next_ip == $past(ip_in)); // R2
  AST_FALLTHROUGH_IP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !taken) |-> next_ip == $past(ip_in)); // R7
  AST_LOOP_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_data == $past(rd_data) - 1'b1); // R5
  AST_LOOP_UNTIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> taken == (wb_data != '0)); // R6
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({not_branch, wb_en}) <= 1); // R2
endmodule

bind branch_decide branch_decide_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ip_in(ip_in),
  .rd_data(rd_data), .out_valid(out_valid), .not_branch(not_branch),
  .taken(taken), .next_ip(next_ip), .wb_en(wb_en), .wb_data(wb_data)
);

// File: tb/branch_decide_bench.sv
module branch_decide_bench;
  localparam int CLK_HALF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0;
  logic [15:0] ip_in = '0;
  logic [2:0]  rd_sel;
  logic [15:0] rd_data = '0;
  logic        out_valid, not_branch, taken, wb_en;
  logic [15:0] next_ip, wb_data;
  logic [2:0]  wb_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #CLK_HALF clk = ~clk;

  branch_decide u_branch_decide (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .ip_in(ip_in),
    .rd_sel(rd_sel), .rd_data(rd_data), .out_valid(out_valid),
    .not_branch(not_branch), .taken(taken), .next_ip(next_ip),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit cond_of(input int s, input bit n, input bit z, input bit c);
    case (s)
      1: return 1;
      2: return z;
      3: return !z;
      4: return !n;
      5: return n;
      6: return c;
      7: return !c;
      default: return 0;
    endcase
  endfunction

  task automatic run_op(input logic [15:0] w, input bit n, input bit z, input bit c,
                        input logic [15:0] ip, input logic [15:0] rv);
    int sel, soff, exp_ip, dec;
    bit br, loop, exp_t;
    @(negedge clk);
    instr = w; flag_n = n; flag_z = z; flag_c = c; ip_in = ip; rd_data = rv;
    in_valid = 1'b1;
    br = w[15] && w[14:12] == 3'b000;
    sel = int'(w[11:9]);
    loop = br && sel == 0;
    #1;
    if (loop) chk("R5 rd_sel", int'(rd_sel), int'(w[8:6]));
    dec = (int'(rv) + 65535) % 65536;
    if (loop) begin
      soff = int'(w[5:0]); if (soff >= 32) soff -= 64;
      exp_t = dec != 0;
    end else begin
      soff = int'(w[8:0]); if (soff >= 256) soff -= 512;
      exp_t = br && cond_of(sel, n, z, c);
    end
    exp_ip = exp_t ? (int'(ip) + 2 * soff + 65536) % 65536 : int'(ip);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 out_valid", int'(out_valid), 1);
    chk("R2 not_branch", int'(not_branch), int'(!br));
    if (loop) begin
      chk("R6 loop taken (R9 flags ignored)", int'(taken), int'(exp_t));
      chk("R6 loop next_ip", int'(next_ip), exp_ip);
      chk("R5 wb_en", int'(wb_en), 1);
      chk("R5 wb_sel", int'(wb_sel), int'(w[8:6]));
      chk("R5 wb_data", int'(wb_data), dec);
    end else if (br) begin
      chk("R3 taken", int'(taken), int'(exp_t));
      chk(exp_t ? "R4 target" : "R7 fallthrough", int'(next_ip), exp_ip);
      chk("R5 wb_en", int'(wb_en), 0);
    end else begin
      chk("R2 taken", int'(taken), 0);
      chk("R2 next_ip", int'(next_ip), int'(ip));
      chk("R2 wb_en", int'(wb_en), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 taken", int'(taken), 0);
    chk("R1 not_branch", int'(not_branch), 0);
    chk("R1 wb_en", int'(wb_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after release", int'(out_valid), 0);
    chk("R1 wb_en after release", int'(wb_en), 0);

    for (int s = 1; s < 8; s++)
      for (int f = 0; f < 8; f++)
        for (int o = 0; o < 512; o += 37)
          run_op(16'h8000 | 16'(s << 9) | 16'(o), f[2], f[1], f[0],
                 16'(16'h4000 + o * 3), 16'h1234);
    for (int s = 1; s < 8; s++) begin
      run_op(16'h8000 | 16'(s << 9) | 16'h1FF, 0, 1, 0, 16'h0000, 0);
      run_op(16'h8000 | 16'(s << 9) | 16'h100, 1, 0, 1, 16'h0100, 0);
      run_op(16'h8000 | 16'(s << 9) | 16'h0FF, 0, 0, 0, 16'hFFF0, 0);
    end

    for (int r = 0; r < 8; r++)
      for (int o = 0; o < 64; o += 9)
        for (int v = 0; v < 5; v++)
          for (int f = 0; f < 8; f++) begin
            logic [15:0] rv;
            case (v)
              0: rv = 16'h0000;
              1: rv = 16'h0001;
              2: rv = 16'h0002;
              3: rv = 16'h8000;
              default: rv = 16'hFFFF;
            endcase
            run_op(16'h8000 | 16'(r << 6) | 16'(o), f[2], f[1], f[0], 16'h2000, rv);
          end

    for (int h = 0; h < 16; h++)
      for (int lo = 0; lo < 4096; lo += 1365)
        if (h != 8) run_op(16'(h << 12) | 16'(lo), 1, 1, 1, 16'hABCE, 16'h0001);

    @(negedge clk);
    chk("R8 idle out_valid", int'(out_valid), 0);
    chk("R8 idle taken", int'(taken), 0);
    chk("R8 idle wb_en", int'(wb_en), 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule